// File: doc/BRIEF.md
# Multi-Port Linked Reservation Monitor

This block gives several requesters that share one word memory a way to perform atomic read-modify-write sequences without a lock. A requester first issues a linked read. That read returns a word and arms a reservation on the line of memory that holds the word. Later the same requester issues a conditional write. The write lands only if the reservation survived. The block reports on the response path whether the write landed, and software uses that flag to decide whether to retry.

Each requester owns exactly one reservation, made of a valid flag and a line tag. A reservation is dropped when any other requester commits a write anywhere in that line. It is also dropped when its owner issues a conditional write. Every requester may present one request per cycle. All requests in a cycle are resolved together and answered one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A linked read (op code 2'b10) returns on the next cycle the memory word at its address and arms the issuing port's reservation with the line tag (address bits above the line offset).
- R2: A committed write by another port (a plain store, or a successful conditional write) anywhere in a reserved line clears that reservation. A linked read whose line is written by another port in the same cycle leaves the reservation disarmed.
- R3: A conditional write (op code 2'b11) updates memory only when the issuing port's reservation is armed. Otherwise the memory is left unchanged.
- R4: Every accepted request produces rsp_vld one cycle later. For a conditional write, rsp_sc_ok is 1 on success and 0 on failure. For any other op, rsp_sc_ok is 0.
- R5: A conditional write clears the issuing port's own reservation whether it succeeds or fails.
- R6: A newer linked read from a port replaces that port's earlier reservation.
- R7: A plain store (op code 2'b01) from a port leaves that port's own reservation armed.
- R8: Reservations are kept at line granularity (LINE_BYTES, 16 bytes by default). A conditional write to any word of the reserved line can succeed. A conditional write to a different line fails.
- R9: Requests in one cycle are ordered by ascending port number. A write from a lower port defeats a higher port's conditional write to the same line. When two plain writes hit the same word in one cycle, the higher port's data is the data that stays in memory.
- R10: After reset, all response outputs are 0, no reservation is armed, and every memory word reads 0.
- R11: Plain loads (op code 2'b00) and linked reads return the memory contents as they stood before the writes of the same cycle. Stores and conditional writes return rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NP | Request valid, one bit per port |
| req_op | input | 2*NP | Op code per port: 00 load, 01 store, 10 linked read, 11 conditional write |
| req_addr | input | NP*ADDR_W | Byte address per port, word aligned |
| req_wdata | input | NP*DATA_W | Write data per port |
| rsp_vld | output | NP | Response valid, one cycle after the request |
| rsp_rdata | output | NP*DATA_W | Read data for load and linked read, zero otherwise |
| rsp_sc_ok | output | NP | Conditional write success flag |

## Verification
Random traffic keeps all ports inside two adjacent lines so that linked reads, stores and conditional writes from different ports often collide on a shared line or word. This exposes any mismatch in when reservations are killed. Directed sequences then separate the individual effects. The own-store case is distinguished from the foreign-store case. A different word in the same line is distinguished from a different line. A double conditional write checks that the reservation is consumed. Simultaneous conditional writes on one line check the port ordering. Memory contents after a failed conditional write are read back with a plain load, which shows whether the failure also blocked the write.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ll_set,
  input  logic [TAG_W-1:0] ll_tag,
  input  logic             link_blk,
  input  logic             sc_done,
  input  logic             kill,
  output logic             resv_vld,
  output logic [TAG_W-1:0] resv_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_vld <= 1'b0;
      resv_tag <= '0;
    end else if (ll_set) begin
      resv_vld <= !link_blk;
      resv_tag <= ll_tag;
    end else if (sc_done || kill) begin
      resv_vld <= 1'b0;
    end
  end

  p_ll_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_set && !link_blk) |=> (resv_vld && resv_tag == $past(ll_tag)));
  p_kill_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !ll_set) |=> !resv_vld);
  p_sc_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |=> !resv_vld);
endmodule

// File: rtl/llsc_commit_arb.sv
module llsc_commit_arb
  import llsc_pkg::*;
#(
  parameter int NP    = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld  [NP],
  input  llsc_op_e         req_op   [NP],
  input  logic [TAG_W-1:0] req_tag  [NP],
  input  logic             resv_vld [NP],
  input  logic [TAG_W-1:0] resv_tag [NP],
  output logic             sc_ok    [NP],
  output logic             wr_en    [NP],
  output logic             kill     [NP],
  output logic             link_blk [NP]
);
  logic wr_v [NP];
  logic ok_v [NP];

  // ports are serialised in ascending order within one cycle
  always_comb begin
    for (int q = 0; q < NP; q++) begin
      logic blocked;
      blocked = 1'b0;
      for (int k = 0; k < q; k++)
        if (wr_v[k] && req_tag[k] == req_tag[q]) blocked = 1'b1;
      ok_v[q] = req_vld[q] && req_op[q] == OP_COND && resv_vld[q]
                && resv_tag[q] == req_tag[q] && !blocked;
      wr_v[q] = (req_vld[q] && req_op[q] == OP_STORE) || ok_v[q];
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      kill[p]     = 1'b0;
      link_blk[p] = 1'b0;
      for (int q = 0; q < NP; q++) begin
        if (q != p && wr_v[q] && req_tag[q] == resv_tag[p]) kill[p] = 1'b1;
        if (q != p && wr_v[q] && req_tag[q] == req_tag[p])  link_blk[p] = 1'b1;
      end
      sc_ok[p] = ok_v[p];
      wr_en[p] = wr_v[p];
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_pi
    for (genvar j = i + 1; j < NP; j++) begin : g_pj
      p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_ok[i] && sc_ok[j] && req_tag[i] == req_tag[j]));
    end
  end
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int NP     = 3,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx  [NP],
  output logic [DATA_W-1:0] rd_data [NP],
  input  logic              wr_en   [NP],
  input  logic [IDX_W-1:0]  wr_idx  [NP],
  input  logic [DATA_W-1:0] wr_data [NP]
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // later (higher) ports override earlier writes to the same word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      for (int p = 0; p < NP; p++)
        if (wr_en[p]) mem[wr_idx[p]] <= wr_data[p];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++)
      rd_data[p] <= rst_n ? mem[rd_idx[p]] : '0;
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NP         = 3,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req_vld,
  input  logic [2*NP-1:0]      req_op,
  input  logic [NP*ADDR_W-1:0] req_addr,
  input  logic [NP*DATA_W-1:0] req_wdata,
  output logic [NP-1:0]        rsp_vld,
  output logic [NP*DATA_W-1:0] rsp_rdata,
  output logic [NP-1:0]        rsp_sc_ok
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WOFF_W     = $clog2(WORD_BYTES);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int TAG_W      = ADDR_W - OFF_W;
  localparam int IDX_W      = ADDR_W - WOFF_W;

  function automatic logic [TAG_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WOFF_W];
  endfunction

  logic              vld_a    [NP];
  llsc_op_e          op_a     [NP];
  logic [TAG_W-1:0]  tag_a    [NP];
  logic [IDX_W-1:0]  idx_a    [NP];
  logic [DATA_W-1:0] wd_a     [NP];
  logic              resv_vld [NP];
  logic [TAG_W-1:0]  resv_tag [NP];
  logic              sc_ok    [NP];
  logic              wr_en    [NP];
  logic              kill     [NP];
  logic              link_blk [NP];
  logic [DATA_W-1:0] rd_data  [NP];
  logic [NP-1:0]     rd_flag_q;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign vld_a[p] = req_vld[p];
    assign op_a[p]  = llsc_op_e'(req_op[2*p +: 2]);
    assign tag_a[p] = line_of(req_addr[p*ADDR_W +: ADDR_W]);
    assign idx_a[p] = word_of(req_addr[p*ADDR_W +: ADDR_W]);
    assign wd_a[p]  = req_wdata[p*DATA_W +: DATA_W];

    llsc_resv_slot #(.TAG_W(TAG_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ll_set   (vld_a[p] && op_a[p] == OP_LINK),
      .ll_tag   (tag_a[p]),
      .link_blk (link_blk[p]),
      .sc_done  (vld_a[p] && op_a[p] == OP_COND),
      .kill     (kill[p]),
      .resv_vld (resv_vld[p]),
      .resv_tag (resv_tag[p])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_vld[p]   <= 1'b0;
        rsp_sc_ok[p] <= 1'b0;
        rd_flag_q[p] <= 1'b0;
      end else begin
        rsp_vld[p]   <= vld_a[p];
        rsp_sc_ok[p] <= sc_ok[p];
        rd_flag_q[p] <= vld_a[p] && (op_a[p] == OP_LOAD || op_a[p] == OP_LINK);
      end
    end

    assign rsp_rdata[p*DATA_W +: DATA_W] = rd_flag_q[p] ? rd_data[p] : '0;

    p_rsp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vld_a[p] |=> rsp_vld[p]);
    p_ok_only_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_a[p] && op_a[p] == OP_COND) |=> !rsp_sc_ok[p]);
    p_ok_needs_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sc_ok[p] |-> $past(resv_vld[p]));
  end

  llsc_commit_arb #(.NP(NP), .TAG_W(TAG_W)) arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (vld_a),
    .req_op   (op_a),
    .req_tag  (tag_a),
    .resv_vld (resv_vld),
    .resv_tag (resv_tag),
    .sc_ok    (sc_ok),
    .wr_en    (wr_en),
    .kill     (kill),
    .link_blk (link_blk)
  );

  llsc_word_mem #(.NP(NP), .IDX_W(IDX_W), .DATA_W(DATA_W)) mem_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx_a),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (idx_a),
    .wr_data (wd_a)
  );
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;
  localparam int NP = 3;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int OFFB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0]    vld;
  logic [1:0]       op_a [NP];
  logic [AW-1:0]    ad_a [NP];
  logic [DW-1:0]    wd_a [NP];
  logic [2*NP-1:0]  req_op;
  logic [NP*AW-1:0] req_addr;
  logic [NP*DW-1:0] req_wdata;
  logic [NP-1:0]    rsp_vld, rsp_sc_ok;
  logic [NP*DW-1:0] rsp_rdata;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req_op[2*p +: 2]     = op_a[p];
      req_addr[p*AW +: AW] = ad_a[p];
      req_wdata[p*DW +: DW] = wd_a[p];
    end
  end

  llsc_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(vld), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0]   mm [64];
  bit              rv [NP];
  logic [AW-5:0]   rt [NP];

  function automatic logic [AW-5:0] ln(input logic [AW-1:0] a);
    return a >> OFFB;
  endfunction

  task automatic idle_all();
    for (int p = 0; p < NP; p++) begin
      vld[p] = 1'b0; op_a[p] = 2'b00; ad_a[p] = '0; wd_a[p] = '0;
    end
  endtask

  task automatic step(input string tag);
    logic [DW-1:0] ex_rd [NP];
    bit ex_ok [NP];
    bit wr [NP];
    bit ex_v [NP];
    for (int p = 0; p < NP; p++) begin
      ex_v[p]  = vld[p];
      ex_rd[p] = (vld[p] && (op_a[p] == 2'b00 || op_a[p] == 2'b10)) ? mm[ad_a[p] >> 2] : '0;
    end
    for (int p = 0; p < NP; p++) begin
      bit blk = 0;
      for (int k = 0; k < p; k++)
        if (wr[k] && ln(ad_a[k]) == ln(ad_a[p])) blk = 1;
      ex_ok[p] = vld[p] && op_a[p] == 2'b11 && rv[p] && rt[p] == ln(ad_a[p]) && !blk;
      wr[p] = (vld[p] && op_a[p] == 2'b01) || ex_ok[p];
    end
    for (int p = 0; p < NP; p++) begin
      bit hit_res = 0, hit_req = 0;
      for (int q = 0; q < NP; q++) if (q != p && wr[q]) begin
        if (ln(ad_a[q]) == rt[p]) hit_res = 1;
        if (ln(ad_a[q]) == ln(ad_a[p])) hit_req = 1;
      end
      if (vld[p] && op_a[p] == 2'b10) begin rv[p] = !hit_req; rt[p] = ln(ad_a[p]); end
      else if ((vld[p] && op_a[p] == 2'b11) || hit_res) rv[p] = 0;
    end
    for (int p = 0; p < NP; p++) if (wr[p]) mm[ad_a[p] >> 2] = wd_a[p];
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      n_chk++;
      if (rsp_vld[p] !== ex_v[p] || rsp_rdata[p*DW +: DW] !== ex_rd[p] || rsp_sc_ok[p] !== ex_ok[p]) begin
        n_bad++;
        $display("FAIL %s port %0d vld/rdata/ok got %b/%h/%b exp %b/%h/%b", tag, p,
                 rsp_vld[p], rsp_rdata[p*DW +: DW], rsp_sc_ok[p], ex_v[p], ex_rd[p], ex_ok[p]);
      end
    end
  endtask

  task automatic one(input int p, input logic [1:0] o, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    idle_all();
    vld[p] = 1'b1; op_a[p] = o; ad_a[p] = a; wd_a[p] = d;
    step(tag);
  endtask

  localparam logic [AW-1:0] A = 8'h40, A2 = 8'h48, B = 8'h50;

  initial begin
    void'($urandom(32'd20240611));
    idle_all();
    for (int w = 0; w < 64; w++) mm[w] = '0;
    for (int p = 0; p < NP; p++) begin rv[p] = 0; rt[p] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state of the outputs
    n_chk++;
    if (rsp_vld !== '0 || rsp_rdata !== '0 || rsp_sc_ok !== '0) begin
      n_bad++;
      $display("FAIL R10 outputs got %b/%h/%b exp 0/0/0", rsp_vld, rsp_rdata, rsp_sc_ok);
    end
    one(0, 2'b00, A, 0, "R10 memory zero");
    one(0, 2'b11, A, 32'h11, "R10 no link after reset");
    // R1 and R3: linked pair succeeds and memory is updated
    one(0, 2'b01, A, 32'hCAFE0001, "R11 store");
    one(0, 2'b10, A, 0, "R1 linked read");
    one(0, 2'b11, A, 32'hBEEF0002, "R3 cond ok");
    one(1, 2'b00, A, 0, "R3 readback");
    // R2: foreign store elsewhere in the line breaks the pair
    one(0, 2'b10, A, 0, "R1 link");
    one(1, 2'b01, A2, 32'h0000AAAA, "R2 foreign store");
    one(0, 2'b11, A, 32'h12345678, "R2 cond fails");
    one(2, 2'b00, A, 0, "R3 unchanged after fail");
    // R7: own store keeps reservation
    one(1, 2'b10, B, 0, "R1 link");
    one(1, 2'b01, B, 32'h77, "R7 own store");
    one(1, 2'b11, B, 32'h78, "R7 cond ok");
    // R5: second conditional fails
    one(1, 2'b11, B, 32'h79, "R5 reservation consumed");
    // R6 and R8
    one(2, 2'b10, A, 0, "R6 first link");
    one(2, 2'b10, B, 0, "R6 replacing link");
    one(2, 2'b11, A, 32'h5, "R6 old line fails");
    one(2, 2'b10, A, 0, "R8 link");
    one(2, 2'b11, A2, 32'h6, "R8 same line other word ok");
    one(2, 2'b10, A, 0, "R8 link");
    one(2, 2'b11, B, 32'h7, "R8 other line fails");
    // R9: two conditionals on one line in one cycle, plus a same-word store
    idle_all();
    vld = '1;
    op_a[0] = 2'b10; ad_a[0] = A;
    op_a[1] = 2'b10; ad_a[1] = A2;
    op_a[2] = 2'b00; ad_a[2] = B;
    step("R9 both link");
    op_a[0] = 2'b11; ad_a[0] = A;  wd_a[0] = 32'h1000;
    op_a[1] = 2'b11; ad_a[1] = A2; wd_a[1] = 32'h2000;
    op_a[2] = 2'b01; ad_a[2] = A;  wd_a[2] = 32'h3000;
    step("R9 lower port wins");
    one(0, 2'b00, A, 0, "R9 higher store data kept");
    // R2: same-cycle foreign write blocks a new link
    idle_all();
    vld[0] = 1; op_a[0] = 2'b01; ad_a[0] = B; wd_a[0] = 32'h9;
    vld[1] = 1; op_a[1] = 2'b10; ad_a[1] = B;
    step("R2 link blocked");
    one(1, 2'b11, B, 32'hA, "R2 blocked link fails");
    // random traffic on two lines
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        vld[p]  = ($urandom % 4) != 0;
        op_a[p] = 2'($urandom % 4);
        ad_a[p] = A + 8'(($urandom % 8) << 2);
        wd_a[p] = $urandom;
      end
      step("R1/R2/R3/R4/R11 random");
    end
    idle_all();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule